// File: doc/BRIEF.md
# Branch Resolution Predictor Command Sequencer

This block sits between the execute stage and the branch predictor. Each cycle the execute stage may offer one resolved-branch record: a reason code, a fault flag, a flag saying whether a prediction was attempted, a fetch sequence number, a thread id and a resolved target address. The block translates that record into zero, one or two ordered commands on the predictor command port. A squash rolls predictor history back to a given sequence number and carries a target and a taken flag. An update retires the prediction for a sequence number.

Both the record input and the command output use a valid/ready handshake. A command stays on the port, with all fields unchanged, until the predictor accepts it. The record input stays closed from the moment a record that needs commands is taken until its last command is accepted. Records that need no commands are taken and dropped without closing the input.

Top module: `bpcmd_sequencer`

## Requirements
- R1: A record with `in_fault`=1, or with `in_tried`=0, produces no command, and `in_ready` stays 1 in the following cycle.
- R2: Reason codes 0 (no branch), 1 (interrupt), 2 (thread suspend), 3 (fetch halt), 4 (self-generated prediction) and all codes 9 to 15 produce no command.
- R3: Reason 5 (unpredicted branch) produces a squash with taken=1 and the record's target, followed by an update.
- R4: Reason 6 (correctly predicted) produces a single update and no squash.
- R5: Reason 7 (predicted taken, resolved not taken) produces a squash with taken=0 followed by an update. The squash target is not specified.
- R6: Reason 8 (taken to a different target) produces a single squash with taken=1 and the record's target, and no update.
- R7: When a record yields both commands, the squash is issued before the update. Every command carries the record's sequence number and thread id.
- R8: While `cmd_valid`=1 and `cmd_ready`=0, `cmd_valid` stays 1 in the next cycle and every command field is unchanged.
- R9: `in_ready` is 0 from the cycle after a commanding record is accepted until the cycle after its last command is accepted. It is 1 whenever no command is pending.
- R10: `cmd_kind` is 0 for a squash and 1 for an update. An update always drives `cmd_taken`=0 and `cmd_target`=0.
- R11: After reset, `cmd_valid`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Resolved-branch record offered |
| in_ready | output | 1 | Block can take a record |
| in_reason | input | 4 | Resolution reason code |
| in_fault | input | 1 | Instruction faulted |
| in_tried | input | 1 | A prediction was attempted for the instruction |
| in_seq | input | SEQ_W | Fetch sequence number |
| in_tid | input | TID_W | Thread id |
| in_target | input | ADDR_W | Resolved target address |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Predictor accepts the command |
| cmd_kind | output | 1 | 0 squash, 1 update |
| cmd_seq | output | SEQ_W | Sequence number of the command |
| cmd_tid | output | TID_W | Thread of the command |
| cmd_target | output | ADDR_W | Squash target (0 on update) |
| cmd_taken | output | 1 | Squash taken flag (0 on update) |

## Verification
A corrupted sequencer state shows up on the command port. Either an update follows a lone target-mismatch squash, or the update is missing after an unpredicted branch. Either fault is visible within the cycle after the squash handshake. A lost capture enable shows as a stale sequence number or target on the first command after a record is accepted. A stuck or early `in_ready` is seen in the cycle after the record is taken, or in any cycle while a command waits. Random back-pressure on `cmd_ready` shows whether fields stay stable across stalls.

// File: rtl/bpcmd_pkg.sv
package bpcmd_pkg;

  localparam int RSN_W = 4;

  typedef enum logic [RSN_W-1:0] {
    RSN_NONE      = 4'd0,
    RSN_IRQ       = 4'd1,
    RSN_SUSPEND   = 4'd2,
    RSN_HALT      = 4'd3,
    RSN_SELFPRED  = 4'd4,
    RSN_UNPRED    = 4'd5,
    RSN_HIT       = 4'd6,
    RSN_WRONG_DIR = 4'd7,
    RSN_WRONG_TGT = 4'd8
  } reason_e;

  typedef struct packed {
    logic squash;
    logic update;
    logic taken;
  } plan_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SQ   = 2'd1,
    ST_UP   = 2'd2
  } state_e;

  localparam logic KIND_SQUASH = 1'b0;
  localparam logic KIND_UPDATE = 1'b1;

endpackage

// File: rtl/bpcmd_rst_sync.sv
module bpcmd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/bpcmd_classify.sv
module bpcmd_classify
  import bpcmd_pkg::*;
(
  input  logic [RSN_W-1:0] reason,
  input  logic             fault,
  input  logic             tried,
  output plan_t            plan
);
  always_comb begin
    plan = '0;
    if (!fault && tried) begin
      case (reason)
        RSN_UNPRED: begin
          plan.squash = 1'b1;
          plan.update = 1'b1;
          plan.taken  = 1'b1;
        end
        RSN_HIT: begin
          plan.update = 1'b1;
        end
        RSN_WRONG_DIR: begin
          plan.squash = 1'b1;
          plan.update = 1'b1;
          plan.taken  = 1'b0;
        end
        RSN_WRONG_TGT: begin
          plan.squash = 1'b1;
          plan.taken  = 1'b1;
        end
        default: plan = '0;
      endcase
    end
  end
endmodule

// File: rtl/bpcmd_hold.sv
module bpcmd_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_next;

  always_comb begin
    q_next = q;
    if (en) q_next = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_next;
  end
endmodule

// File: rtl/bpcmd_issue_fsm.sv
module bpcmd_issue_fsm
  import bpcmd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rec_valid,
  input  plan_t plan,
  input  logic  cmd_ready,
  output logic  rec_ready,
  output logic  cmd_valid,
  output logic  cmd_kind,
  output logic  cmd_taken,
  output logic  capture
);
  state_e state_q, state_d;
  logic   upd_pend_q, upd_pend_d;
  logic   taken_q, taken_d;

  assign rec_ready = (state_q == ST_IDLE);
  assign capture   = rec_valid && rec_ready;

  always_comb begin
    state_d    = state_q;
    upd_pend_d = upd_pend_q;
    taken_d    = taken_q;
    case (state_q)
      ST_IDLE: begin
        if (capture) begin
          upd_pend_d = plan.update;
          taken_d    = plan.taken;
          if (plan.squash)      state_d = ST_SQ;
          else if (plan.update) state_d = ST_UP;
        end
      end
      ST_SQ: begin
        if (cmd_ready) state_d = upd_pend_q ? ST_UP : ST_IDLE;
      end
      ST_UP: begin
        if (cmd_ready) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      upd_pend_q <= 1'b0;
      taken_q    <= 1'b0;
    end else begin
      state_q    <= state_d;
      upd_pend_q <= upd_pend_d;
      taken_q    <= taken_d;
    end
  end

  assign cmd_valid = (state_q == ST_SQ) || (state_q == ST_UP);
  assign cmd_kind  = (state_q == ST_UP) ? KIND_UPDATE : KIND_SQUASH;
  assign cmd_taken = (state_q == ST_SQ) && taken_q;
endmodule

// File: rtl/bpcmd_sequencer.sv
module bpcmd_sequencer
  import bpcmd_pkg::*;
#(
  parameter int SEQ_W  = 16,
  parameter int TID_W  = 2,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [RSN_W-1:0]  in_reason,
  input  logic              in_fault,
  input  logic              in_tried,
  input  logic [SEQ_W-1:0]  in_seq,
  input  logic [TID_W-1:0]  in_tid,
  input  logic [ADDR_W-1:0] in_target,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_kind,
  output logic [SEQ_W-1:0]  cmd_seq,
  output logic [TID_W-1:0]  cmd_tid,
  output logic [ADDR_W-1:0] cmd_target,
  output logic              cmd_taken
);
  localparam int REC_W = SEQ_W + TID_W + ADDR_W;

  logic              rst_n_int;
  plan_t             plan;
  logic              capture;
  logic [REC_W-1:0]  rec_q;
  logic [ADDR_W-1:0] tgt_q;

  bpcmd_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  bpcmd_classify u_cls (
    .reason (in_reason),
    .fault  (in_fault),
    .tried  (in_tried),
    .plan   (plan)
  );

  bpcmd_issue_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .rec_valid (in_valid),
    .plan      (plan),
    .cmd_ready (cmd_ready),
    .rec_ready (in_ready),
    .cmd_valid (cmd_valid),
    .cmd_kind  (cmd_kind),
    .cmd_taken (cmd_taken),
    .capture   (capture)
  );

  bpcmd_hold #(.W(REC_W)) u_rec (
    .clk   (clk),
    .rst_n (rst_n_int),
    .en    (capture),
    .d     ({in_seq, in_tid, in_target}),
    .q     (rec_q)
  );

  assign cmd_seq    = rec_q[REC_W-1 -: SEQ_W];
  assign cmd_tid    = rec_q[ADDR_W +: TID_W];
  assign tgt_q      = rec_q[ADDR_W-1:0];
  assign cmd_target = (cmd_valid && cmd_kind == KIND_SQUASH) ? tgt_q : '0;
endmodule

// File: rtl/bpcmd_sequencer_chk.sv
module bpcmd_sequencer_chk
  import bpcmd_pkg::*;
#(
  parameter int SEQ_W  = 16,
  parameter int TID_W  = 2,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [RSN_W-1:0]  in_reason,
  input logic              in_fault,
  input logic              in_tried,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              cmd_kind,
  input logic [SEQ_W-1:0]  cmd_seq,
  input logic [TID_W-1:0]  cmd_tid,
  input logic [ADDR_W-1:0] cmd_target,
  input logic              cmd_taken
);
  // R1
  filtered_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (in_fault || !in_tried)) |=> (!cmd_valid && in_ready));

  // R2
  noaction_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (in_reason < 4'd5 || in_reason > 4'd8)) |=> !cmd_valid);

  // R7
  squash_then_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_kind == KIND_SQUASH) |=>
      (!cmd_valid || (cmd_kind == KIND_UPDATE && $stable(cmd_seq) && $stable(cmd_tid))));

  // R7
  update_is_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_kind == KIND_UPDATE) |=> !cmd_valid);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=>
      (cmd_valid && $stable(cmd_kind) && $stable(cmd_seq) && $stable(cmd_tid)
       && $stable(cmd_target) && $stable(cmd_taken)));

  // R9
  closed_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !in_ready);

  // R10
  update_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_kind == KIND_UPDATE) |-> (!cmd_taken && cmd_target == '0));
endmodule

bind bpcmd_sequencer bpcmd_sequencer_chk #(
  .SEQ_W(SEQ_W), .TID_W(TID_W), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/sim_bpcmd_sequencer.sv
`timescale 1ns/1ps
module sim_bpcmd_sequencer;
  localparam int SEQ_W  = 16;
  localparam int TID_W  = 2;
  localparam int ADDR_W = 32;

  logic              clk;
  logic              rst_n;
  logic              in_valid;
  logic              in_ready;
  logic [3:0]        in_reason;
  logic              in_fault;
  logic              in_tried;
  logic [SEQ_W-1:0]  in_seq;
  logic [TID_W-1:0]  in_tid;
  logic [ADDR_W-1:0] in_target;
  logic              cmd_valid;
  logic              cmd_ready;
  logic              cmd_kind;
  logic [SEQ_W-1:0]  cmd_seq;
  logic [TID_W-1:0]  cmd_tid;
  logic [ADDR_W-1:0] cmd_target;
  logic              cmd_taken;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  bpcmd_sequencer #(.SEQ_W(SEQ_W), .TID_W(TID_W), .ADDR_W(ADDR_W)) u0 (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Applies one record, collects the commands, compares with the model.
  task automatic run_rec(input logic [3:0] rsn, input logic flt, input logic tr,
                         input logic [SEQ_W-1:0] sq, input logic [TID_W-1:0] td,
                         input logic [ADDR_W-1:0] tg, input bit stall, input string tag);
    int   exp_n;
    logic e_kind [2];
    logic e_tk   [2];
    bit   e_tgt  [2];
    int   got;
    bit   prev_stall;
    logic p_kind, p_tk;
    logic [SEQ_W-1:0]  p_seq;
    logic [TID_W-1:0]  p_tid;
    logic [ADDR_W-1:0] p_tgt;
    exp_n = 0;
    if (!flt && tr) begin
      case (rsn)
        4'd5: begin exp_n = 2; e_kind[0]=0; e_tk[0]=1; e_tgt[0]=1; e_kind[1]=1; e_tk[1]=0; e_tgt[1]=1; end
        4'd6: begin exp_n = 1; e_kind[0]=1; e_tk[0]=0; e_tgt[0]=1; end
        4'd7: begin exp_n = 2; e_kind[0]=0; e_tk[0]=0; e_tgt[0]=0; e_kind[1]=1; e_tk[1]=0; e_tgt[1]=1; end
        4'd8: begin exp_n = 1; e_kind[0]=0; e_tk[0]=1; e_tgt[0]=1; end
        default: exp_n = 0;
      endcase
    end
    @(negedge clk);
    in_valid = 1'b1; in_reason = rsn; in_fault = flt; in_tried = tr;
    in_seq = sq; in_tid = td; in_target = tg;
    #1;
    chk(in_ready == 1'b1, "R9", {tag, " open before record"}, in_ready, 1);
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    chk(in_ready == (exp_n == 0), exp_n == 0 ? "R1" : "R9",
        {tag, " in_ready after accept"}, in_ready, exp_n == 0);
    got = 0;
    prev_stall = 1'b0;
    p_kind = 0; p_tk = 0; p_seq = '0; p_tid = '0; p_tgt = '0;
    for (int cyc = 0; cyc < 24; cyc++) begin
      if (cyc > 0) @(negedge clk);
      cmd_ready = stall ? 1'($urandom % 2) : 1'b1;
      #1;
      if (prev_stall) begin
        chk(cmd_valid && cmd_kind == p_kind && cmd_seq == p_seq && cmd_tid == p_tid
            && cmd_target == p_tgt && cmd_taken == p_tk, "R8", {tag, " hold under stall"},
            {cmd_valid, cmd_kind, cmd_seq}, {1'b1, p_kind, p_seq});
      end
      if (cmd_valid)
        chk(in_ready == 1'b0, "R9", {tag, " closed while command pending"}, in_ready, 0);
      prev_stall = cmd_valid && !cmd_ready;
      p_kind = cmd_kind; p_tk = cmd_taken; p_seq = cmd_seq; p_tid = cmd_tid; p_tgt = cmd_target;
      if (cmd_valid && cmd_ready) begin
        if (got < exp_n) begin
          chk(cmd_kind == e_kind[got], "R7", {tag, " command order/kind"}, cmd_kind, e_kind[got]);
          chk(cmd_seq == sq && cmd_tid == td, "R7", {tag, " seq/tid"},
              {cmd_seq, cmd_tid}, {sq, td});
          chk(cmd_taken == e_tk[got], tag, " taken flag", cmd_taken, e_tk[got]);
          if (e_tgt[got])
            chk(cmd_target == (e_kind[got] ? '0 : tg), e_kind[got] ? "R10" : tag,
                {tag, " target"}, cmd_target, e_kind[got] ? 0 : tg);
        end else begin
          chk(1'b0, tag, " extra command", cmd_kind, 0);
        end
        got++;
      end
    end
    cmd_ready = 1'b0;
    chk(got == exp_n, tag, " command count", got, exp_n);
    #1;
    chk(in_ready == 1'b1 && cmd_valid == 1'b0, "R9", {tag, " reopened after sequence"},
        {in_ready, cmd_valid}, 2'b10);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 0; in_reason = 0; in_fault = 0; in_tried = 0;
    in_seq = '0; in_tid = '0; in_target = '0; cmd_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(cmd_valid == 1'b0, "R11", "cmd_valid after reset", cmd_valid, 0);
    chk(in_ready == 1'b1, "R11", "in_ready after reset", in_ready, 1);
  endtask

  task automatic t_filtered();
    run_rec(4'd5, 1'b1, 1'b1, 16'h0011, 2'd1, 32'h1000_0040, 1'b0, "R1");
    run_rec(4'd8, 1'b0, 1'b0, 16'h0012, 2'd2, 32'h1000_0080, 1'b0, "R1");
    run_rec(4'd6, 1'b1, 1'b0, 16'h0013, 2'd3, 32'h1000_00c0, 1'b0, "R1");
  endtask

  task automatic t_noaction();
    for (int c = 0; c < 16; c++)
      if (c < 5 || c > 8)
        run_rec(4'(c), 1'b0, 1'b1, 16'(16'h0100 + c), 2'(c), 32'(32'h2000_0000 + c * 4), 1'b0, "R2");
  endtask

  task automatic t_unpred();
    run_rec(4'd5, 1'b0, 1'b1, 16'hbeef, 2'd2, 32'hdead_b000, 1'b0, "R3");
  endtask

  task automatic t_hit();
    run_rec(4'd6, 1'b0, 1'b1, 16'h4242, 2'd1, 32'h0000_1234, 1'b0, "R4");
  endtask

  task automatic t_wrongdir();
    run_rec(4'd7, 1'b0, 1'b1, 16'h7001, 2'd3, 32'hffff_fff0, 1'b0, "R5");
  endtask

  task automatic t_wrongtgt();
    run_rec(4'd8, 1'b0, 1'b1, 16'h8002, 2'd0, 32'h0badc0de, 1'b0, "R6");
  endtask

  task automatic t_stalls();
    for (int rep = 0; rep < 6; rep++) begin
      run_rec(4'd5, 1'b0, 1'b1, 16'(16'h9000 + rep), 2'(rep), 32'(32'h3000_0000 + rep * 16), 1'b1, "R3");
      run_rec(4'd6, 1'b0, 1'b1, 16'(16'h9100 + rep), 2'(rep), 32'(32'h3100_0000 + rep * 16), 1'b1, "R4");
      run_rec(4'd7, 1'b0, 1'b1, 16'(16'h9200 + rep), 2'(rep), 32'(32'h3200_0000 + rep * 16), 1'b1, "R5");
      run_rec(4'd8, 1'b0, 1'b1, 16'(16'h9300 + rep), 2'(rep), 32'(32'h3300_0000 + rep * 16), 1'b1, "R6");
    end
  endtask

  initial begin
    t_reset();
    t_filtered();
    t_noaction();
    t_unpred();
    t_hit();
    t_wrongdir();
    t_wrongtgt();
    t_stalls();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL R9 watchdog: actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule